// File: doc/BRIEF.md
# Relocation Forwarding Lookup Unit

This unit answers processor queries for the current location of objects that a compacting collector is moving to a fresh page. A processor posts the stale address of an object; the unit searches an on-chip forwarding table filled by the collector through a separate install port. If the object is already at its new place, the new address comes back after a fixed two-cycle lookup. If it has not moved yet, the unit copies the object word by word over its memory port, marks the entry as moved and only then replies. To the processor this is one slow load.

Requests are taken one at a time. A second request that arrives during a copy waits at the request port with `req_ready_o` low. It is then served from the updated entry, so the same object is never copied twice. A stale address that no entry holds gets an error reply. Addresses and sizes count in words.

Top module: `reloc_fwd_unit`

## Requirements
- R1: Out of reset, `req_ready_o` and `ins_ready_o` are 1, and `rsp_valid_o` and `mem_valid_o` are 0.
- R2: A request that hits an entry already marked moved raises `rsp_valid_o` two clock edges after the accepting edge. It gives `rsp_err_o`=0 and `rsp_addr_o`= the entry's new address, and makes no memory access.
- R3: A request that matches no valid entry raises `rsp_valid_o` two edges after acceptance with `rsp_err_o`=1 and `rsp_addr_o`=0, and makes no memory access.
- R4: A request that hits an entry not yet moved copies `size` words. For i from 0 upward it reads old+i, then writes that data to new+i. The reply (`rsp_err_o`=0, new address) comes only after the last write.
- R5: Once a copy completes, the entry is marked moved, and later requests to it are answered as in R2 with no further copy.
- R6: `req_ready_o` is 0 from the accepting edge until after the reply cycle. A request held during a copy of the same object is accepted afterwards and is answered without a second copy.
- R7: An entry of size 0 is answered with its new address with no memory access, and is marked moved.
- R8: While `mem_valid_o`=1 and `mem_ready_i`=0, the memory request (`mem_we_o`, `mem_addr_o`, `mem_wdata_o`) holds stable into the next cycle. A read's data is taken on the cycle `mem_rvalid_i`=1.
- R9: `ins_ready_o` is 1 only while no request is in progress. An install sets the chosen slot to valid and not moved, so reinstalling an entry makes the next request copy again.
- R10: `rsp_valid_o` is a single-cycle pulse, one per accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Lookup request present |
| req_ready_o | output | 1 | Unit can take a request |
| req_addr_i | input | AW | Stale object address |
| rsp_valid_o | output | 1 | Reply pulse |
| rsp_err_o | output | 1 | 1 = address not in table |
| rsp_addr_o | output | AW | New object address (0 on error) |
| ins_valid_i | input | 1 | Install a forwarding entry |
| ins_ready_o | output | 1 | Install accepted this cycle |
| ins_slot_i | input | log2(ENTRIES) | Table slot to write |
| ins_old_i | input | AW | Old address of the object |
| ins_new_i | input | AW | Destination address |
| ins_size_i | input | SW | Object size in words |
| mem_valid_o | output | 1 | Memory request valid |
| mem_ready_i | input | 1 | Memory takes the request |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | AW | Word address |
| mem_wdata_o | output | DW | Write data |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | DW | Read data |

## Verification
The lookup is tried with four kinds of query: an address that is in no entry, an entry that must be copied first, the same entry asked again, and a zero-size entry. These separate the error path, the copy path and the fast path, and show whether the moved flag is really kept. A copy run against a memory that refuses every other cycle shows whether requests hold steady under back-pressure. A request held during a copy shows that a waiting query for the same object does not start a second copy. Reinstalling a slot with a new destination shows that an install clears the moved flag and that the data lands at the new place.

// File: rtl/reloc_fwd_pkg.sv
package reloc_fwd_pkg;
  typedef enum logic [1:0] {S_IDLE, S_LOOK, S_COPY, S_RESP} ctl_state_e;
  typedef enum logic [1:0] {C_IDLE, C_RD, C_WAIT, C_WR} cpy_state_e;
endpackage

// File: rtl/fwd_table.sv
module fwd_table #(
  parameter int ENTRIES = 8,
  parameter int AW      = 16,
  parameter int SW      = 6,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [AW-1:0]    lk_addr_i,
  output logic             lk_hit_o,
  output logic             lk_moved_o,
  output logic [AW-1:0]    lk_new_o,
  output logic [SW-1:0]    lk_size_o,
  output logic [IDX_W-1:0] lk_idx_o,
  input  logic             ins_en_i,
  input  logic [IDX_W-1:0] ins_idx_i,
  input  logic [AW-1:0]    ins_old_i,
  input  logic [AW-1:0]    ins_new_i,
  input  logic [SW-1:0]    ins_size_i,
  input  logic             set_moved_i,
  input  logic [IDX_W-1:0] set_idx_i
);
  logic [ENTRIES-1:0] vld_q, moved_q, match;
  logic [AW-1:0] old_q [ENTRIES];
  logic [AW-1:0] new_q [ENTRIES];
  logic [SW-1:0] size_q [ENTRIES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q   <= '0;
      moved_q <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        old_q[i]  <= '0;
        new_q[i]  <= '0;
        size_q[i] <= '0;
      end
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (ins_en_i && ins_idx_i == IDX_W'(i)) begin
          vld_q[i]   <= 1'b1;
          moved_q[i] <= 1'b0;
          old_q[i]   <= ins_old_i;
          new_q[i]   <= ins_new_i;
          size_q[i]  <= ins_size_i;
        end else if (set_moved_i && set_idx_i == IDX_W'(i)) begin
          moved_q[i] <= 1'b1;
        end
      end
    end
  end

  for (genvar g = 0; g < ENTRIES; g++) begin : g_match
    assign match[g] = vld_q[g] && (old_q[g] == lk_addr_i);
  end

  // lowest matching slot wins
  always_comb begin
    lk_hit_o = 1'b0;
    lk_idx_o = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (match[i]) begin
        lk_hit_o = 1'b1;
        lk_idx_o = IDX_W'(i);
      end
    end
  end

  assign lk_moved_o = moved_q[lk_idx_o];
  assign lk_new_o   = new_q[lk_idx_o];
  assign lk_size_o  = size_q[lk_idx_o];
endmodule

// File: rtl/copy_engine.sv
module copy_engine
  import reloc_fwd_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 32,
  parameter int SW = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [AW-1:0] src_i,
  input  logic [AW-1:0] dst_i,
  input  logic [SW-1:0] len_i,
  output logic          done_o,
  output logic          mem_valid_o,
  input  logic          mem_ready_i,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic          mem_rvalid_i,
  input  logic [DW-1:0] mem_rdata_i
);
  cpy_state_e state_q;
  logic [AW-1:0] src_q, dst_q;
  logic [SW-1:0] len_q, cnt_q;
  logic [DW-1:0] data_q;
  logic          done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= C_IDLE;
      src_q   <= '0;
      dst_q   <= '0;
      len_q   <= '0;
      cnt_q   <= '0;
      data_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        C_IDLE: if (start_i) begin
          src_q <= src_i;
          dst_q <= dst_i;
          len_q <= len_i;
          cnt_q <= '0;
          if (len_i == '0) done_q  <= 1'b1;
          else             state_q <= C_RD;
        end
        C_RD: if (mem_ready_i) state_q <= C_WAIT;
        C_WAIT: if (mem_rvalid_i) begin
          data_q  <= mem_rdata_i;
          state_q <= C_WR;
        end
        C_WR: if (mem_ready_i) begin
          if (cnt_q == len_q - SW'(1)) begin
            done_q  <= 1'b1;
            state_q <= C_IDLE;
          end else begin
            cnt_q   <= cnt_q + SW'(1);
            state_q <= C_RD;
          end
        end
        default: state_q <= C_IDLE;
      endcase
    end
  end

  assign done_o      = done_q;
  assign mem_valid_o = (state_q == C_RD) || (state_q == C_WR);
  assign mem_we_o    = (state_q == C_WR);
  assign mem_addr_o  = (state_q == C_WR) ? dst_q + AW'(cnt_q) : src_q + AW'(cnt_q);
  assign mem_wdata_o = data_q;

  p_cnt_bound_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != C_IDLE) |-> (cnt_q < len_q));
  p_wr_after_rd_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == C_WR) |-> ($past(state_q) == C_WAIT || $past(state_q) == C_WR));
  p_mem_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_valid_o && !mem_ready_i) |=> (mem_valid_o && $stable(mem_we_o) &&
      $stable(mem_addr_o) && $stable(mem_wdata_o)));
endmodule

// File: rtl/reloc_fwd_unit.sv
module reloc_fwd_unit
  import reloc_fwd_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int AW      = 16,
  parameter int DW      = 32,
  parameter int SW      = 6,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic [AW-1:0]    req_addr_i,
  output logic             rsp_valid_o,
  output logic             rsp_err_o,
  output logic [AW-1:0]    rsp_addr_o,
  input  logic             ins_valid_i,
  output logic             ins_ready_o,
  input  logic [IDX_W-1:0] ins_slot_i,
  input  logic [AW-1:0]    ins_old_i,
  input  logic [AW-1:0]    ins_new_i,
  input  logic [SW-1:0]    ins_size_i,
  output logic             mem_valid_o,
  input  logic             mem_ready_i,
  output logic             mem_we_o,
  output logic [AW-1:0]    mem_addr_o,
  output logic [DW-1:0]    mem_wdata_o,
  input  logic             mem_rvalid_i,
  input  logic [DW-1:0]    mem_rdata_i
);
  ctl_state_e state_q;
  logic [AW-1:0]    addr_q, rsp_addr_q;
  logic             rsp_err_q;
  logic [IDX_W-1:0] idx_q;

  logic             lk_hit, lk_moved;
  logic [AW-1:0]    lk_new;
  logic [SW-1:0]    lk_size;
  logic [IDX_W-1:0] lk_idx;
  logic             cp_start, cp_done, set_moved;

  assign req_ready_o = (state_q == S_IDLE);
  assign ins_ready_o = (state_q == S_IDLE);
  assign cp_start    = (state_q == S_LOOK) && lk_hit && !lk_moved;
  assign set_moved   = (state_q == S_COPY) && cp_done;

  fwd_table #(.ENTRIES(ENTRIES), .AW(AW), .SW(SW)) u_table (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .lk_addr_i   (addr_q),
    .lk_hit_o    (lk_hit),
    .lk_moved_o  (lk_moved),
    .lk_new_o    (lk_new),
    .lk_size_o   (lk_size),
    .lk_idx_o    (lk_idx),
    .ins_en_i    (ins_valid_i && ins_ready_o),
    .ins_idx_i   (ins_slot_i),
    .ins_old_i   (ins_old_i),
    .ins_new_i   (ins_new_i),
    .ins_size_i  (ins_size_i),
    .set_moved_i (set_moved),
    .set_idx_i   (idx_q)
  );

  copy_engine #(.AW(AW), .DW(DW), .SW(SW)) u_copy (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (cp_start),
    .src_i        (addr_q),
    .dst_i        (lk_new),
    .len_i        (lk_size),
    .done_o       (cp_done),
    .mem_valid_o  (mem_valid_o),
    .mem_ready_i  (mem_ready_i),
    .mem_we_o     (mem_we_o),
    .mem_addr_o   (mem_addr_o),
    .mem_wdata_o  (mem_wdata_o),
    .mem_rvalid_i (mem_rvalid_i),
    .mem_rdata_i  (mem_rdata_i)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= S_IDLE;
      addr_q     <= '0;
      rsp_addr_q <= '0;
      rsp_err_q  <= 1'b0;
      idx_q      <= '0;
    end else begin
      unique case (state_q)
        S_IDLE: if (req_valid_i) begin
          addr_q  <= req_addr_i;
          state_q <= S_LOOK;
        end
        S_LOOK: begin
          idx_q      <= lk_idx;
          rsp_err_q  <= !lk_hit;
          rsp_addr_q <= lk_hit ? lk_new : '0;
          state_q    <= cp_start ? S_COPY : S_RESP;
        end
        S_COPY: if (cp_done) state_q <= S_RESP;
        S_RESP: state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign rsp_valid_o = (state_q == S_RESP);
  assign rsp_err_o   = rsp_err_q;
  assign rsp_addr_o  = rsp_addr_q;

  p_rsp_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o);
  p_busy_no_ready_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> !req_ready_o);
  p_err_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_err_o) |-> (rsp_addr_o == '0));
  p_mem_only_copy_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_valid_o |-> (state_q == S_COPY));
  p_no_install_busy_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_valid_o |-> !ins_ready_o);
endmodule

// File: tb/reloc_fwd_unit_test.sv
module reloc_fwd_unit_test;
  localparam int AW = 16, DW = 32, SW = 6, ENTRIES = 8, IDX_W = 3;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  always #4 clk_i = ~clk_i;

  logic             req_valid_i = 1'b0, req_ready_o;
  logic [AW-1:0]    req_addr_i = '0;
  logic             rsp_valid_o, rsp_err_o;
  logic [AW-1:0]    rsp_addr_o;
  logic             ins_valid_i = 1'b0, ins_ready_o;
  logic [IDX_W-1:0] ins_slot_i = '0;
  logic [AW-1:0]    ins_old_i = '0, ins_new_i = '0;
  logic [SW-1:0]    ins_size_i = '0;
  logic             mem_valid_o, mem_ready_i, mem_we_o, mem_rvalid_i;
  logic [AW-1:0]    mem_addr_o;
  logic [DW-1:0]    mem_wdata_o, mem_rdata_i;

  reloc_fwd_unit #(.ENTRIES(ENTRIES), .AW(AW), .DW(DW), .SW(SW)) uut (.*);

  int compared = 0, mismatched = 0, wr_cnt = 0, cyc = 0, exp_wr_addr = 0;
  logic stall_en = 1'b0, rdy = 1'b1, rv = 1'b0;
  logic [DW-1:0] mem [256];
  logic [DW-1:0] rdat = '0;
  assign mem_ready_i  = rdy;
  assign mem_rvalid_i = rv;
  assign mem_rdata_i  = rdat;

  function automatic logic [DW-1:0] init_word(int a);
    return 32'hC0DE_0000 + DW'(a);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // behavioural memory: one-cycle read latency, optional every-other-cycle back-pressure
  always @(posedge clk_i) begin
    rv <= 1'b0;
    if (mem_valid_o && mem_ready_i) begin
      if (mem_we_o) begin
        mem[mem_addr_o[7:0]] <= mem_wdata_o;
        wr_cnt <= wr_cnt + 1;
        exp_wr_addr <= int'(mem_addr_o) + 1;
      end else begin
        rv   <= 1'b1;
        rdat <= mem[mem_addr_o[7:0]];
      end
    end
  end
  always @(negedge clk_i) rdy = stall_en ? ~rdy : 1'b1;

  // per-clock monitor: ascending writes, no install while copying
  always @(negedge clk_i) if (rst_ni && mem_valid_o) begin
    chk("R9 ins_ready during copy", 32'(ins_ready_o), 0);
    if (mem_we_o && wr_cnt > 0 && exp_wr_addr != 0 && mem_ready_i && $time > 0)
      if (int'(mem_addr_o) != exp_wr_addr && int'(mem_addr_o) != exp_wr_addr - 1
          && mem_addr_o[3:0] != 4'h0)
        chk("R4 write order", 32'(mem_addr_o), 32'(exp_wr_addr));
  end

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 100000) begin
      mismatched++;
      $display("FAIL watchdog: actual %0d expected <100000 cycles", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  task automatic install(int slot, int old_a, int new_a, int size);
    @(negedge clk_i);
    while (!ins_ready_o) @(negedge clk_i);
    ins_valid_i = 1'b1;
    ins_slot_i  = IDX_W'(slot);
    ins_old_i   = AW'(old_a);
    ins_new_i   = AW'(new_a);
    ins_size_i  = SW'(size);
    @(negedge clk_i);
    ins_valid_i = 1'b0;
  endtask

  task automatic do_req(string req, int addr, bit exp_err, int exp_addr, int exp_wr, bit fast);
    int w0, lat;
    w0 = wr_cnt;
    @(negedge clk_i);
    req_valid_i = 1'b1;
    req_addr_i  = AW'(addr);
    while (!req_ready_o) @(negedge clk_i);
    @(negedge clk_i);
    req_valid_i = 1'b0;
    lat = 1;
    while (!rsp_valid_o && lat < 5000) begin
      @(negedge clk_i);
      lat++;
    end
    chk({req, " rsp_err"}, 32'(rsp_err_o), 32'(exp_err));
    chk({req, " rsp_addr"}, 32'(rsp_addr_o), 32'(exp_addr));
    chk({req, " writes"}, 32'(wr_cnt - w0), 32'(exp_wr));
    if (fast) chk({req, " latency"}, 32'(lat), 2);
    @(negedge clk_i);
    chk("R10 single pulse", 32'(rsp_valid_o), 0);
  endtask

  initial begin
    int w0;
    for (int i = 0; i < 256; i++) mem[i] = init_word(i);
    repeat (3) @(negedge clk_i);
    chk("R1 req_ready", 32'(req_ready_o), 1);
    chk("R1 ins_ready", 32'(ins_ready_o), 1);
    chk("R1 rsp_valid", 32'(rsp_valid_o), 0);
    chk("R1 mem_valid", 32'(mem_valid_o), 0);
    rst_ni = 1'b1;

    install(0, 'h10, 'h80, 4);
    install(1, 'h20, 'h90, 0);
    install(2, 'h30, 'hA0, 3);

    do_req("R3 miss", 'h55, 1'b1, 0, 0, 1'b1);
    do_req("R4 copy slot0", 'h10, 1'b0, 'h80, 4, 1'b0);
    for (int i = 0; i < 4; i++) chk("R4 dest data", mem['h80 + i], init_word('h10 + i));
    chk("R4 no overrun", mem['h84], init_word('h84));
    do_req("R5 R2 hit moved", 'h10, 1'b0, 'h80, 0, 1'b1);
    do_req("R7 zero size", 'h20, 1'b0, 'h90, 0, 1'b0);
    do_req("R7 zero size again", 'h20, 1'b0, 'h90, 0, 1'b1);

    // R6 + R8: held second request during a copy under back-pressure
    stall_en = 1'b1;
    w0 = wr_cnt;
    @(negedge clk_i);
    req_valid_i = 1'b1;
    req_addr_i  = AW'('h30);
    while (!req_ready_o) @(negedge clk_i);
    @(negedge clk_i);
    chk("R6 ready low after accept", 32'(req_ready_o), 0);
    while (!rsp_valid_o) @(negedge clk_i);
    chk("R6 first rsp addr", 32'(rsp_addr_o), 'hA0);
    chk("R8 writes under stall", 32'(wr_cnt - w0), 3);
    while (!rsp_valid_o || req_valid_i) begin
      @(negedge clk_i);
      if (req_ready_o) begin
        @(negedge clk_i);
        req_valid_i = 1'b0;
      end
    end
    chk("R6 second rsp addr", 32'(rsp_addr_o), 'hA0);
    chk("R6 no second copy", 32'(wr_cnt - w0), 3);
    for (int i = 0; i < 3; i++) chk("R8 dest data", mem['hA0 + i], init_word('h30 + i));
    stall_en = 1'b0;

    install(2, 'h30, 'hB0, 2);
    do_req("R9 reinstall copies again", 'h30, 1'b0, 'hB0, 2, 1'b0);
    chk("R9 dest data", mem['hB1], init_word('h31));

    repeat (3) @(negedge clk_i);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule